// File: doc/BRIEF.md
# Cache-Line Range Chunking Engine

This engine turns one cache-maintenance request, given as a byte range [start, end) with a command code and a way mask, into an ordered stream of line-aligned commands for a cache controller. It rounds the start down to a line boundary. It rounds the covered length up to whole lines and cuts it into chunks that never exceed a fixed maximum. When the span would wrap almost the whole address space, it sends a single whole-cache command instead of range chunks. Every request ends with a sync command.

Invalidate requests get special handling at their edges. An invalidate must not discard neighbouring bytes that happen to share a line with the range. So a partially covered first line and a partially covered last line are each flushed as single-line commands. Only the fully covered interior is invalidated.

Commands leave on a valid/ready port and are held stable until they are taken. While a request is in progress, `busy` is high and new requests are not accepted.

Top module: `range_chunker`

## Requirements
- R1: After reset, `busy` and `out_valid` are low.
- R2: A request is taken in a cycle where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the cycle after the sync command is handed off. Requests presented while `busy` is high have no effect on the command stream.
- R3: For a non-invalidate code, the start is rounded down to a multiple of 2^LINE_LG. The size is end minus the aligned start, modulo 2^ADDR_W, rounded up to whole lines. Range commands (kind 0) carry that code and cover the size in increasing address order. Each is at most 2^CHUNK_LG − 2^LINE_LG bytes, and only the last may be shorter.
- R4: If the size before rounding is at least 2^ADDR_W − 2^LINE_LG, a single whole-cache command (kind 1, address 0, size 0, the request code) replaces all range commands.
- R5: The last command of every request is a sync (kind 2, address 0, size 0, the request code).
- R6: For invalidate (code 0) with an unaligned start, the line holding the start is first flushed as one range command (code 2, size one line). The start then moves to the next line boundary, with no wraparound.
- R7: For invalidate with an unaligned end, if the advanced start is still below the end, the line holding the end is flushed as one line (code 2). The end is then rounded down.
- R8: For invalidate, if the advanced start is not below the rounded-down end, only the sync follows the edge flushes. Otherwise the interior is processed as in R3/R4 with code 0.
- R9: A command is held unchanged while `out_valid` is high and `out_ready` is low. Every command carries the request's way mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_start | input | ADDR_W | First byte of the range |
| req_end | input | ADDR_W | Byte after the range |
| req_code | input | 3 | Maintenance code (0 invalidate, 1 clean, 2 flush) |
| req_ways | input | WAY_W | Way mask passed through |
| busy | output | 1 | Request in progress |
| out_valid | output | 1 | Command present |
| out_ready | input | 1 | Consumer takes the command |
| out_kind | output | 2 | 0 range, 1 whole cache, 2 sync |
| out_addr | output | ADDR_W | Command address |
| out_size | output | ADDR_W | Command size in bytes |
| out_code | output | 3 | Command code |
| out_ways | output | WAY_W | Way mask |

## Verification
The assertions assume that the consumer drives `out_ready` as a plain input with no dependence on `out_valid`. They also assume that reset is held for at least one clock edge before requests begin. The bench meets both conditions. It drives `out_ready` from a free pseudo-random pattern, changes inputs only on falling edges, and keeps `req_valid` asserted with unrelated values throughout every busy period, so that the stall and ignore paths are exercised. A reduced configuration (10-bit addresses, 4-byte lines, 12-byte chunks) is swept over start and end points that cluster around line edges, the top of the address space and wraparound.

// File: rtl/rc_pkg.sv
// Shared encodings for the range chunking engine.
// Assumes a 3-bit maintenance code field.
package rc_pkg;
    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] CODE_INV   = 3'd0;
    localparam logic [CODE_W-1:0] CODE_FLUSH = 3'd2;

    typedef enum logic [1:0] {
        KIND_RANGE = 2'd0,
        KIND_ALL   = 2'd1,
        KIND_SYNC  = 2'd2
    } rc_kind_e;

    typedef enum logic [2:0] {
        PH_HEAD, PH_TAIL, PH_ALL, PH_BODY, PH_SYNC
    } rc_phase_e;
endpackage

// File: rtl/rc_plan.sv
// Request decoder: from a raw range and code, works out the edge flushes,
// the interior base, the rounded interior length and the whole-cache case.
// Assumes LINE_LG < ADDR_W. Purely combinational.
module rc_plan
    import rc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LINE_LG = 7
) (
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] end_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              head_en,
    output logic [ADDR_W-1:0] head_addr,
    output logic              tail_en,
    output logic [ADDR_W-1:0] tail_addr,
    output logic              all_en,
    output logic [ADDR_W-1:0] body_addr,
    output logic [ADDR_W-1:0] body_len
);
    localparam logic [ADDR_W-1:0] LINE    = ADDR_W'(1) << LINE_LG;
    localparam logic [ADDR_W-1:0] HI_MASK = ~(LINE - ADDR_W'(1));
    // 2^ADDR_W - LINE equals the high-part mask
    localparam logic [ADDR_W-1:0] WRAP_THR = HI_MASK;

    logic              is_inv;
    logic [ADDR_W-1:0] a_start, a_end, span_end, raw;
    logic [ADDR_W:0]   adv_start;
    logic              body_on;

    // Edge handling, interior span and wrap detection
    always_comb begin
        is_inv    = (code_i == CODE_INV);
        a_start   = start_i & HI_MASK;
        a_end     = end_i & HI_MASK;
        head_en   = is_inv && (start_i[LINE_LG-1:0] != '0);
        adv_start = {1'b0, a_start} + (head_en ? {1'b0, LINE} : '0);
        tail_en   = is_inv && (end_i[LINE_LG-1:0] != '0)
                    && (adv_start < {1'b0, end_i});
        span_end  = is_inv ? a_end : end_i;
        body_on   = !is_inv || (adv_start < {1'b0, a_end});
        raw       = span_end - adv_start[ADDR_W-1:0];
        all_en    = body_on && (raw >= WRAP_THR);
        head_addr = a_start;
        tail_addr = a_end;
        body_addr = adv_start[ADDR_W-1:0];
        body_len  = (body_on && !all_en) ? ((raw + LINE - ADDR_W'(1)) & HI_MASK) : '0;
    end
endmodule

// File: rtl/rc_chunk.sv
// Chunk sizer: clamps the remaining interior length to the maximum chunk.
// Assumes LINE_LG < CHUNK_LG <= ADDR_W.
module rc_chunk #(
    parameter int ADDR_W   = 32,
    parameter int LINE_LG  = 7,
    parameter int CHUNK_LG = 22
) (
    input  logic [ADDR_W-1:0] remain_i,
    output logic [ADDR_W-1:0] chunk_o
);
    localparam logic [ADDR_W-1:0] CHUNK_MAX =
        ADDR_W'((64'd1 << CHUNK_LG) - (64'd1 << LINE_LG));

    // Pick the smaller of remaining length and maximum chunk
    always_comb chunk_o = (remain_i > CHUNK_MAX) ? CHUNK_MAX : remain_i;
endmodule

// File: rtl/rc_pick.sv
// Phase selector: orders pending work as head flush, tail flush,
// whole-cache, interior chunks, then sync.
module rc_pick
    import rc_pkg::*;
(
    input  logic      head_pend,
    input  logic      tail_pend,
    input  logic      all_pend,
    input  logic      body_pend,
    output rc_phase_e phase_o
);
    // Fixed priority over pending flags
    always_comb begin
        if (head_pend)      phase_o = PH_HEAD;
        else if (tail_pend) phase_o = PH_TAIL;
        else if (all_pend)  phase_o = PH_ALL;
        else if (body_pend) phase_o = PH_BODY;
        else                phase_o = PH_SYNC;
    end
endmodule

// File: rtl/range_chunker.sv
// Range chunking engine top: accepts one maintenance request at a time and
// emits line-aligned range, whole-cache and sync commands on a valid/ready
// port. Assumes the consumer's ready does not depend on out_valid.
module range_chunker
    import rc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_LG  = 7,
    parameter int CHUNK_LG = 22,
    parameter int WAY_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic [2:0]        req_code,
    input  logic [WAY_W-1:0]  req_ways,
    output logic              busy,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ADDR_W-1:0] out_size,
    output logic [2:0]        out_code,
    output logic [WAY_W-1:0]  out_ways
);
    localparam logic [ADDR_W-1:0] LINE = ADDR_W'(1) << LINE_LG;
    localparam logic [ADDR_W-1:0] CHUNK_MAX =
        ADDR_W'((64'd1 << CHUNK_LG) - (64'd1 << LINE_LG));

    logic              p_head, p_tail, p_all;
    logic [ADDR_W-1:0] p_head_addr, p_tail_addr, p_body_addr, p_body_len;
    logic              head_q, tail_q, all_q;
    logic [ADDR_W-1:0] head_addr_q, tail_addr_q, cur_q, remain_q;
    logic [CODE_W-1:0] code_q;
    logic [WAY_W-1:0]  ways_q;
    logic [ADDR_W-1:0] chunk;
    rc_phase_e         phase;
    logic              accept, hs;

    rc_plan #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) i_plan (
        .start_i(req_start), .end_i(req_end), .code_i(req_code),
        .head_en(p_head), .head_addr(p_head_addr),
        .tail_en(p_tail), .tail_addr(p_tail_addr),
        .all_en(p_all), .body_addr(p_body_addr), .body_len(p_body_len)
    );

    rc_chunk #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG), .CHUNK_LG(CHUNK_LG)) i_chunk (
        .remain_i(remain_q), .chunk_o(chunk)
    );

    rc_pick i_pick (
        .head_pend(head_q), .tail_pend(tail_q), .all_pend(all_q),
        .body_pend(remain_q != '0), .phase_o(phase)
    );

    assign accept    = req_valid && !busy;
    assign out_valid = busy;
    assign hs        = out_valid && out_ready;

    // Request capture and per-command progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            head_q   <= 1'b0;
            tail_q   <= 1'b0;
            all_q    <= 1'b0;
            remain_q <= '0;
        end else if (accept) begin
            busy        <= 1'b1;
            head_q      <= p_head;
            tail_q      <= p_tail;
            all_q       <= p_all;
            head_addr_q <= p_head_addr;
            tail_addr_q <= p_tail_addr;
            cur_q       <= p_body_addr;
            remain_q    <= p_body_len;
            code_q      <= req_code;
            ways_q      <= req_ways;
        end else if (hs) begin
            case (phase)
                PH_HEAD: head_q <= 1'b0;
                PH_TAIL: tail_q <= 1'b0;
                PH_ALL:  all_q  <= 1'b0;
                PH_BODY: begin
                    cur_q    <= cur_q + chunk;
                    remain_q <= remain_q - chunk;
                end
                default: busy <= 1'b0;
            endcase
        end
    end

    // Command fields for the current phase
    always_comb begin
        out_ways = ways_q;
        out_code = code_q;
        out_addr = '0;
        out_size = '0;
        out_kind = KIND_SYNC;
        case (phase)
            PH_HEAD: begin
                out_kind = KIND_RANGE; out_addr = head_addr_q;
                out_size = LINE;       out_code = CODE_FLUSH;
            end
            PH_TAIL: begin
                out_kind = KIND_RANGE; out_addr = tail_addr_q;
                out_size = LINE;       out_code = CODE_FLUSH;
            end
            PH_ALL:  out_kind = KIND_ALL;
            PH_BODY: begin
                out_kind = KIND_RANGE; out_addr = cur_q; out_size = chunk;
            end
            default: out_kind = KIND_SYNC;
        endcase
    end

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R2
    idle_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && out_kind == KIND_SYNC) |=> !busy);

    // R9
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind)
            && $stable(out_addr) && $stable(out_size) && $stable(out_code)
            && $stable(out_ways)));

    // R3
    range_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == KIND_RANGE) |-> (out_size != '0
            && out_size <= CHUNK_MAX && out_size[LINE_LG-1:0] == '0
            && out_addr[LINE_LG-1:0] == '0));

    // R5
    sync_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind != KIND_RANGE) |-> (out_addr == '0 && out_size == '0));
endmodule

// File: tb/test_range_chunker.sv
module test_range_chunker;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int LG = 2;
    localparam int CLG = 4;
    localparam int WW = 8;
    localparam int SPACE = 1 << AW;
    localparam int LN = 1 << LG;
    localparam int CMAX = (1 << CLG) - LN;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, out_ready = 1'b0;
    logic [AW-1:0] req_start = '0, req_end = '0;
    logic [2:0] req_code = '0;
    logic [WW-1:0] req_ways = '0;
    logic busy, out_valid;
    logic [1:0] out_kind;
    logic [AW-1:0] out_addr, out_size;
    logic [2:0] out_code;
    logic [WW-1:0] out_ways;

    int checks = 0, fails = 0;
    bit done = 0;

    int e_kind[128], e_addr[128], e_size[128], e_code[128];
    string e_tag[128];
    int e_n;
    int pts[18] = '{0, 1, 2, 3, 4, 5, 7, 8, 13, 100, 511, 512, 1015, 1016, 1019, 1020, 1021, 1023};

    always #(CLK_PERIOD/2) clk = ~clk;

    range_chunker #(.ADDR_W(AW), .LINE_LG(LG), .CHUNK_LG(CLG), .WAY_W(WW)) i_range_chunker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_start(req_start),
        .req_end(req_end), .req_code(req_code), .req_ways(req_ways), .busy(busy),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_addr(out_addr), .out_size(out_size), .out_code(out_code), .out_ways(out_ways));

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push(int k, int a, int s, int c, string tag);
        e_kind[e_n] = k; e_addr[e_n] = a; e_size[e_n] = s; e_code[e_n] = c; e_tag[e_n] = tag;
        e_n++;
    endtask

    task automatic model_body(int a, int raw, int c, string tag);
        int sz;
        if (raw >= SPACE - LN) begin
            push(1, 0, 0, c, "R4");
        end else begin
            sz = (raw + LN - 1) / LN * LN;
            while (sz > 0) begin
                int ch = (sz > CMAX) ? CMAX : sz;
                push(0, a, ch, c, tag);
                a = (a + ch) % SPACE;
                sz -= ch;
            end
        end
    endtask

    task automatic model(int s, int e, int c);
        int as2, s2, e2;
        e_n = 0;
        as2 = s / LN * LN;
        if (c == 0) begin
            s2 = s;
            if (s % LN != 0) begin
                push(0, as2, LN, 2, "R6");
                s2 = as2 + LN;
            end
            if (e % LN != 0 && s2 < e) push(0, e / LN * LN, LN, 2, "R7");
            e2 = e / LN * LN;
            if (s2 < e2) model_body(s2, e2 - s2, 0, "R8");
        end else begin
            model_body(as2, (e - as2 + SPACE) % SPACE, c, "R3");
        end
        push(2, 0, 0, c, "R5");
    endtask

    task automatic run_one(int s, int e, int c, int w);
        int idx = 0, guard = 0;
        bit stalled = 0;
        int h_kind = 0, h_addr = 0, h_size = 0, h_code = 0, h_ways = 0;
        bit fin = 0;
        model(s, e, c);
        @(negedge clk);
        req_valid = 1; req_start = AW'(s); req_end = AW'(e);
        req_code = 3'(c); req_ways = WW'(w);
        @(negedge clk);
        check(busy === 1'b1, "R2", "busy after accept", int'(busy), 1);
        // unrelated request held while busy: must be ignored
        req_start = AW'(s + 37); req_end = AW'(e + 91); req_code = 3'(c ^ 1); req_ways = ~WW'(w);
        while (!fin && guard < 1000) begin
            guard++;
            out_ready = ($urandom % 4) != 0;
            #1;
            if (stalled) begin
                check(out_valid && out_kind == h_kind && out_addr == h_addr && out_size == h_size
                      && out_code == h_code && out_ways == h_ways, "R9", "held command", int'(out_addr), h_addr);
                stalled = 0;
            end
            if (out_valid && !out_ready) begin
                stalled = 1;
                h_kind = out_kind; h_addr = out_addr; h_size = out_size; h_code = out_code; h_ways = out_ways;
            end else if (out_valid && out_ready) begin
                if (idx >= e_n) begin
                    check(0, "R8", "extra command", idx, e_n);
                    fin = 1;
                end else begin
                    check(out_kind == e_kind[idx], e_tag[idx], "kind", int'(out_kind), e_kind[idx]);
                    check(out_addr == e_addr[idx] && out_size == e_size[idx] && out_code == e_code[idx],
                          e_tag[idx], "addr/size/code", int'(out_addr) * 10000 + int'(out_size) * 10 + int'(out_code),
                          e_addr[idx] * 10000 + e_size[idx] * 10 + e_code[idx]);
                    check(out_ways == w, "R9", "way mask", int'(out_ways), w);
                    if (out_kind == 2) fin = 1;
                    idx++;
                end
            end
            @(negedge clk);
        end
        check(idx == e_n, "R5", "command count", idx, e_n);
        check(busy === 1'b0, "R2", "idle after sync", int'(busy), 0);
        req_valid = 0;
        out_ready = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R1", "busy at reset", int'(busy), 0);
        check(out_valid === 1'b0, "R1", "out_valid at reset", int'(out_valid), 0);
        rst_n = 1;
        @(negedge clk);
        check(busy === 1'b0 && out_valid === 1'b0, "R1", "idle after reset", int'(busy), 0);
        for (int c = 0; c < 3; c++)
            for (int i = 0; i < 18; i++)
                for (int j = 0; j < 18; j++)
                    run_one(pts[i], pts[j], c, (i * 18 + j + c * 7) % 256);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule